// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a start/stop framed serial bit stream into parallel characters. A falling edge on the idle-high line opens a frame. The line is sampled once per bit, at the middle of the bit, using a clock that runs at sixteen times the bit rate. The data bits arrive least significant bit first. One optional trailing bit follows them, and a stop bit closes the frame. Each completed character appears on the outputs together with a one-cycle valid pulse. A parity-error flag and a framing-error flag sit beside the data and hold their values until the next character completes.

The receiver shares its mode settings with a companion transmitter. These settings are the rate prescaler and divisor, the character length, parity enable and parity sense, one or two stop bits, and multi-processor addressing. In multi-processor mode the bit after the data is an address/data marker rather than a parity bit. The receiver brings that marker out and performs no parity check. A settings write has an effect only while the transmitter and the receiver are both disabled.

Top module: `async_rx`

## Requirements
- R1: After reset, rx_valid, rx_data, rx_bit8, rx_mpb, rx_perr and rx_ferr are all 0, and the settings are an 8-bit character, no parity, one stop bit, prescale /1 and divisor 0.
- R2: A character is taken in with its least significant bit first. Each completed frame raises rx_valid for exactly one clock cycle.
- R3: The two-bit length code selects the number of data bits. Codes 00 and 01 give 9 bits, with the ninth bit on rx_bit8. Code 10 gives 8 bits. Code 11 gives 7 bits, with rx_data[7] forced to 0. rx_bit8 is 0 for every length except 9 bits.
- R4: With parity enabled and multi-processor mode off, a parity bit follows the data. A parity-sense value of 0 expects even parity over the data and parity bit together; a value of 1 expects odd parity. A mismatch sets rx_perr with that character.
- R5: With parity disabled, no parity bit is expected, the stop bit directly follows the last data bit, and rx_perr stays 0.
- R6: In multi-processor mode, the single bit after the data is presented on rx_mpb. The parity settings are ignored and rx_perr stays 0.
- R7: A 0 in the first stop bit sets rx_ferr. When two stop bits are selected, the second one is waited through but not checked.
- R8: A low pulse that has already ended by the middle of the start bit is discarded as a false start, and no character results from it.
- R9: The oversampling tick period is P×(D+1) clock cycles. P is 1, 4, 16 or 64 for prescale codes 00, 01, 10 and 11, and D is the divisor. One bit lasts 16 ticks.
- R10: A settings write is applied only while tx_en and rx_en are both 0. At any other time the write is ignored.
- R11: While rx_en is 0, line activity produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Companion transmitter enable (only used to block settings writes) |
| rx_en | input | 1 | Receiver enable |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_clk_sel | input | 2 | Prescale code: 00=/1, 01=/4, 10=/16, 11=/64 |
| cfg_len | input | 2 | Length code: 00/01=9 bits, 10=8 bits, 11=7 bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_mp_en | input | 1 | Multi-processor mode |
| cfg_div | input | DIV_W | Tick divisor D |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Received character, low eight bits |
| rx_bit8 | output | 1 | Ninth data bit in 9-bit mode |
| rx_mpb | output | 1 | Captured multi-processor bit |
| rx_valid | output | 1 | One-cycle pulse when a character completes |
| rx_perr | output | 1 | Parity error of the last character |
| rx_ferr | output | 1 | Framing error of the last character |

## Verification
Some properties are checked on every cycle. The valid pulse always lasts a single cycle. The character outputs stay within their length rules: rx_data[7] is 0 in 7-bit mode and rx_bit8 is 0 outside 9-bit mode. rx_perr stays 0 whenever parity is disabled or multi-processor mode is on. Settings hold while either enable is set. A disabled receiver never completes a character. A high line at the middle of the start bit sends the receiver back to idle. At prescale values other than /1, ticks are never adjacent. Other behaviour can only be shown by the bench scenarios: the actual bit order, parity sense, framing detection, the second stop bit being ignored, and bit timing at several prescaler settings. For these, the bench drives whole frames and compares the characters that come out against a queue of expected results.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   typedef struct packed {
      logic [1:0] clk_sel;
      logic [1:0] len_code;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
      logic       mp_en;
   } rx_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_EXTRA,
      ST_STOP1,
      ST_STOP2
   } rx_state_e;

   localparam rx_cfg_t CFG_RESET = '{clk_sel: 2'b00, len_code: 2'b10, par_en: 1'b0,
                                     par_odd: 1'b0, two_stop: 1'b0, mp_en: 1'b0};

   function automatic logic [3:0] char_bits(input logic [1:0] code);
      case (code)
         2'b10:   char_bits = 4'd8;
         2'b11:   char_bits = 4'd7;
         default: char_bits = 4'd9;
      endcase
   endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic line,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("async_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr[0] <= 1'b1;
            else        sr[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr[i] <= 1'b1;
            else        sr[i] <= sr[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= sr[STAGES-1];

   assign line = sr[STAGES-1];
   assign fall = prev & ~sr[STAGES-1];
endmodule

// File: rtl/async_rx_tick.sv
module async_rx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [1:0]       clk_sel,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PRE_W = 6;

   if (DIV_W < 1) begin : g_bad_div
      $error("async_rx_tick: DIV_W must be positive");
   end

   logic [PRE_W-1:0] pre_cnt, pre_max;
   logic [DIV_W-1:0] div_cnt;
   logic             pre_hit;

   always_comb begin
      case (clk_sel)
         2'b00:   pre_max = PRE_W'(0);
         2'b01:   pre_max = PRE_W'(3);
         2'b10:   pre_max = PRE_W'(15);
         default: pre_max = PRE_W'(63);
      endcase
   end

   assign pre_hit = (pre_cnt == pre_max);
   assign tick    = pre_hit && (div_cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (clr) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (pre_hit) begin
         pre_cnt <= '0;
         div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // R9: with a prescale of four or more, two ticks never fall on adjacent cycles
   assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clk_sel != 2'b00) |=> (!tick || clk_sel == 2'b00));
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
   import async_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    rx_en,
   input  logic    tick,
   input  logic    line,
   input  logic    fall,
   input  rx_cfg_t cfg,
   output logic    tick_clr,
   output logic [7:0] rx_data,
   output logic    rx_bit8,
   output logic    rx_mpb,
   output logic    rx_valid,
   output logic    rx_perr,
   output logic    rx_ferr
);
   localparam int OS_W = $clog2(OVS);
   localparam logic [OS_W-1:0] MID = OS_W'(OVS / 2 - 1);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("async_rx_frame: OVS must be a power of two, at least 4");
   end

   rx_state_e       state;
   logic [OS_W-1:0] os_cnt;
   logic [3:0]      bit_idx;
   logic [8:0]      shreg;
   logic            ext_q;
   logic            at_mid;
   logic [3:0]      last_idx;
   logic            has_extra;
   logic            chk_par;

   assign at_mid    = tick && (os_cnt == MID);
   assign last_idx  = char_bits(cfg.len_code) - 4'd1;
   assign has_extra = cfg.mp_en | cfg.par_en;
   assign chk_par   = cfg.par_en & ~cfg.mp_en;
   assign tick_clr  = (state == ST_IDLE) && rx_en && fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         os_cnt   <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         ext_q    <= 1'b0;
         rx_data  <= '0;
         rx_bit8  <= 1'b0;
         rx_mpb   <= 1'b0;
         rx_valid <= 1'b0;
         rx_perr  <= 1'b0;
         rx_ferr  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (state != ST_IDLE && tick) os_cnt <= os_cnt + 1'b1;
         if (!rx_en) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: if (fall) begin
                  state  <= ST_START;
                  os_cnt <= '0;
               end
               ST_START: if (at_mid) begin
                  if (line) begin
                     state <= ST_IDLE;
                  end else begin
                     state   <= ST_DATA;
                     bit_idx <= '0;
                     shreg   <= '0;
                     ext_q   <= 1'b0;
                  end
               end
               ST_DATA: if (at_mid) begin
                  shreg[bit_idx] <= line;
                  if (bit_idx == last_idx) state <= has_extra ? ST_EXTRA : ST_STOP1;
                  else                     bit_idx <= bit_idx + 1'b1;
               end
               ST_EXTRA: if (at_mid) begin
                  ext_q <= line;
                  state <= ST_STOP1;
               end
               ST_STOP1: if (at_mid) begin
                  rx_valid <= 1'b1;
                  rx_data  <= shreg[7:0];
                  rx_bit8  <= (cfg.len_code[1] == 1'b0) & shreg[8];
                  rx_mpb   <= cfg.mp_en & ext_q;
                  rx_perr  <= chk_par & ((^{shreg, ext_q}) != cfg.par_odd);
                  rx_ferr  <= ~line;
                  state    <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
               end
               ST_STOP2: if (at_mid) state <= ST_IDLE;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2: the completion strobe lasts one cycle
   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R3: the top data bit is clear for 7-bit characters
   assert_len7_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg.len_code == 2'b11) |-> !rx_data[7]);
   // R3: the ninth bit stays clear unless the length is 9
   assert_bit8_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg.len_code[1]) |-> !rx_bit8);
   // R5: with parity off, no parity error is reported
   assert_nopar_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg.par_en) |-> !rx_perr);
   // R6: multi-processor mode suppresses parity checking
   assert_mp_noperr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg.mp_en) |-> !rx_perr);
   // R8: a high line at the start-bit midpoint returns to idle
   assert_false_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && state == ST_START && at_mid && line) |=> state == ST_IDLE);
   // R11: a disabled receiver never completes a character
   assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_valid);
endmodule

// File: rtl/async_rx.sv
module async_rx
   import async_rx_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_clk_sel,
   input  logic [1:0]       cfg_len,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   input  logic             cfg_two_stop,
   input  logic             cfg_mp_en,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             rxd,
   output logic [7:0]       rx_data,
   output logic             rx_bit8,
   output logic             rx_mpb,
   output logic             rx_valid,
   output logic             rx_perr,
   output logic             rx_ferr
);
   rx_cfg_t          cfg_q;
   logic [DIV_W-1:0] div_q;
   logic             wr_ok;
   logic             line, fall, tick, tick_clr;

   assign wr_ok = cfg_wr & ~tx_en & ~rx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         div_q <= '0;
      end else if (wr_ok) begin
         cfg_q <= '{clk_sel: cfg_clk_sel, len_code: cfg_len, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, two_stop: cfg_two_stop, mp_en: cfg_mp_en};
         div_q <= cfg_div;
      end
   end

   // R10: settings are frozen while either direction is enabled
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || rx_en) |=> ($stable(cfg_q) && $stable(div_q)));

   async_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(rxd), .line(line), .fall(fall));

   async_rx_tick #(.DIV_W(DIV_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .clr(tick_clr), .clk_sel(cfg_q.clk_sel),
      .div(div_q), .tick(tick));

   async_rx_frame #(.OVS(OVS)) frame_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .line(line),
      .fall(fall), .cfg(cfg_q), .tick_clr(tick_clr), .rx_data(rx_data),
      .rx_bit8(rx_bit8), .rx_mpb(rx_mpb), .rx_valid(rx_valid),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr));
endmodule

// File: tb/async_rx_tb_top.sv
`timescale 1ns/1ps
module async_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, rx_en = 1'b0, cfg_wr = 1'b0;
   logic [1:0] cfg_clk_sel = 2'b00, cfg_len = 2'b10;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_mp_en = 1'b0;
   logic [7:0] cfg_div = 8'd0;
   logic       rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_bit8, rx_mpb, rx_valid, rx_perr, rx_ferr;

   always #5 clk = ~clk;

   async_rx dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cfg_wr(cfg_wr),
      .cfg_clk_sel(cfg_clk_sel), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_mp_en(cfg_mp_en),
      .cfg_div(cfg_div), .rxd(rxd), .rx_data(rx_data), .rx_bit8(rx_bit8),
      .rx_mpb(rx_mpb), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr));

   typedef struct {
      logic [7:0] d;
      logic       b8, mpb, perr, ferr;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0, n_fail = 0, n_valid = 0;
   int   bit_t = 16;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // monitor: pops expected characters as the design completes them
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         n_valid++;
         if (exp_q.size() == 0) begin
            check("unexpected character (R8/R11)", {23'd0, rx_data, rx_bit8}, 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, {rx_data, rx_bit8, rx_mpb, rx_perr, rx_ferr},
                  {e.d, e.b8, e.mpb, e.perr, e.ferr});
         end
      end
   end

   task automatic set_cfg(input logic [1:0] cs, input logic [7:0] dv, input logic [1:0] ln,
                          input logic pe, input logic po, input logic ts, input logic mp);
      @(negedge clk);
      rx_en = 1'b0;
      cfg_clk_sel = cs; cfg_div = dv; cfg_len = ln; cfg_par_en = pe;
      cfg_par_odd = po; cfg_two_stop = ts; cfg_mp_en = mp; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      rx_en  = 1'b1;
      bit_t  = 16 * (cs == 2'b00 ? 1 : cs == 2'b01 ? 4 : cs == 2'b10 ? 16 : 64) * (dv + 1);
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (bit_t) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input int nb, input logic has_x, input logic x,
                       input logic s1, input logic has_s2, input logic s2);
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (has_x) drive_bit(x);
      drive_bit(s1);
      if (has_s2) drive_bit(s2);
      rxd = 1'b1;
      repeat (2 * bit_t) @(negedge clk);
   endtask

   task automatic expect_c(input logic [7:0] d, input logic b8, input logic mpb,
                           input logic pe, input logic fe, input string tag);
      exp_t e;
      e.d = d; e.b8 = b8; e.mpb = mpb; e.perr = pe; e.ferr = fe; e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 outputs at reset", {rx_data, rx_bit8, rx_mpb, rx_valid, rx_perr, rx_ferr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset settings receive an 8-bit, no-parity character at 16 cycles per bit
      rx_en = 1'b1; bit_t = 16;
      expect_c(8'hA5, 0, 0, 0, 0, "R1 reset settings");
      send(9'h0A5, 8, 0, 0, 1, 0, 0);

      // R2 / R5: 8-bit characters, LSB first, no parity bit
      set_cfg(2'b00, 8'd0, 2'b10, 0, 0, 0, 0);
      expect_c(8'h3C, 0, 0, 0, 0, "R2 byte 3C");
      send(9'h03C, 8, 0, 0, 1, 0, 0);
      expect_c(8'h81, 0, 0, 0, 0, "R5 byte 81 no parity");
      send(9'h081, 8, 0, 0, 1, 0, 0);

      // R3: 7-bit, 9-bit code 00 and code 01
      set_cfg(2'b00, 8'd0, 2'b11, 0, 0, 0, 0);
      expect_c(8'h7F, 0, 0, 0, 0, "R3 seven bits");
      send(9'h07F, 7, 0, 0, 1, 0, 0);
      set_cfg(2'b00, 8'd0, 2'b00, 0, 0, 0, 0);
      expect_c(8'hA5, 1, 0, 0, 0, "R3 nine bits code00");
      send(9'h1A5, 9, 0, 0, 1, 0, 0);
      set_cfg(2'b00, 8'd0, 2'b01, 0, 0, 0, 0);
      expect_c(8'h5A, 0, 0, 0, 0, "R3 nine bits code01");
      send(9'h05A, 9, 0, 0, 1, 0, 0);

      // R4: even and odd parity, good and bad
      set_cfg(2'b00, 8'd0, 2'b10, 1, 0, 0, 0);
      expect_c(8'h13, 0, 0, 0, 0, "R4 even ok");
      send(9'h013, 8, 1, ^8'h13, 1, 0, 0);
      expect_c(8'h13, 0, 0, 1, 0, "R4 even bad");
      send(9'h013, 8, 1, ~^8'h13, 1, 0, 0);
      set_cfg(2'b00, 8'd0, 2'b10, 1, 1, 0, 0);
      expect_c(8'hF0, 0, 0, 0, 0, "R4 odd ok");
      send(9'h0F0, 8, 1, ~^8'hF0, 1, 0, 0);
      expect_c(8'hF0, 0, 0, 1, 0, "R4 odd bad");
      send(9'h0F0, 8, 1, ^8'hF0, 1, 0, 0);

      // R6: multi-processor bit with parity settings ignored
      set_cfg(2'b00, 8'd0, 2'b10, 1, 0, 0, 1);
      expect_c(8'h01, 0, 1, 0, 0, "R6 mp bit 1");
      send(9'h001, 8, 1, 1, 1, 0, 0);
      expect_c(8'h01, 0, 0, 0, 0, "R6 mp bit 0");
      send(9'h001, 8, 1, 0, 1, 0, 0);

      // R7: framing error, and an unchecked second stop bit
      set_cfg(2'b00, 8'd0, 2'b10, 0, 0, 0, 0);
      expect_c(8'h55, 0, 0, 0, 1, "R7 bad stop");
      send(9'h055, 8, 0, 0, 0, 0, 0);
      set_cfg(2'b00, 8'd0, 2'b10, 0, 0, 1, 0);
      expect_c(8'hAA, 0, 0, 0, 0, "R7 second stop low ignored");
      send(9'h0AA, 8, 0, 0, 1, 1, 0);
      expect_c(8'h66, 0, 0, 0, 0, "R7 frame after two stops");
      send(9'h066, 8, 0, 0, 1, 1, 1);

      // R8: short low glitch is discarded
      set_cfg(2'b00, 8'd0, 2'b10, 0, 0, 0, 0);
      seen = n_valid;
      rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
      repeat (48) @(negedge clk);
      check("R8 glitch gives no character", n_valid, seen);
      expect_c(8'hC7, 0, 0, 0, 0, "R8 frame after glitch");
      send(9'h0C7, 8, 0, 0, 1, 0, 0);

      // R9: prescaler and divisor timing
      set_cfg(2'b01, 8'd1, 2'b10, 0, 0, 0, 0);
      expect_c(8'h9E, 0, 0, 0, 0, "R9 /4 div1");
      send(9'h09E, 8, 0, 0, 1, 0, 0);
      set_cfg(2'b10, 8'd0, 2'b10, 0, 0, 0, 0);
      expect_c(8'h2D, 0, 0, 0, 0, "R9 /16");
      send(9'h02D, 8, 0, 0, 1, 0, 0);
      set_cfg(2'b11, 8'd0, 2'b10, 0, 0, 0, 0);
      expect_c(8'hB4, 0, 0, 0, 0, "R9 /64");
      send(9'h0B4, 8, 0, 0, 1, 0, 0);

      // R10: write while enabled is ignored (would otherwise select 7 bits and /4)
      set_cfg(2'b00, 8'd0, 2'b10, 0, 0, 0, 0);
      @(negedge clk);
      cfg_len = 2'b11; cfg_clk_sel = 2'b01; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      tx_en = 1'b1; rx_en = 1'b0; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; tx_en = 1'b0; rx_en = 1'b1;
      expect_c(8'hC3, 0, 0, 0, 0, "R10 settings unchanged");
      send(9'h0C3, 8, 0, 0, 1, 0, 0);

      // R11: disabled receiver ignores a full frame
      rx_en = 1'b0;
      seen = n_valid;
      send(9'h0E1, 8, 0, 0, 1, 0, 0);
      check("R11 no character while disabled", n_valid, seen);
      rx_en = 1'b1;
      @(negedge clk);
      expect_c(8'h1E, 0, 0, 0, 0, "R11 re-enabled frame");
      send(9'h01E, 8, 0, 0, 1, 0, 0);

      check("R2 all expected characters delivered", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule